// File: doc/BRIEF.md
# Ethernet MAC Mode and Enable Control Register

This block holds the eight-bit control word of an Ethernet MAC and derives the enable lines for the receiver, the transmitter and the MII management logic from it. Software writes and reads the word over a simple strobe-and-data interface. The block checks each write against three status inputs (transmit-active, management-busy and low-power wait) and refuses the changes that would be unsafe at that moment.

The register holds five live fields: a MAC run bit, a power-down-in-wait bit, an external-PHY select, a MAC loopback select and a full-duplex bit. The external-PHY select can be set only once per reset. When the MAC stops running, whether because software clears the run bit, wait mode is gated off, or software reset clears the word, the block sends the datapath a one-cycle pulse. The pulse drops any frame being received and clears the pause timeout.

Top module: `emac_ctl_reg`

## Requirements
- R1: The read word places the run bit at bit 7, power-down-in-wait at bit 4, external-PHY select at bit 3, loopback at bit 2 and full duplex at bit 1. Bits 6, 5 and 0 always read 0 and ignore writes. An accepted write shows on the read port from the next cycle.
- R2: After hardware reset the read word is 0x00, the receive, transmit, pulse and error outputs are low, and the management enable is high.
- R3: The first write accepted while the run bit is 0 and management-busy is low loads the external-PHY select and locks it. Every later write leaves that bit unchanged until a reset.
- R4: A write made while the run bit is 1 or management-busy is high leaves the external-PHY select unchanged and does not use up the single allowed write.
- R5: A write that sets the run bit from 0 and in the same write changes the loopback or external-PHY bit applies the mode change but leaves the run bit at 0.
- R6: A write that would clear the run bit while transmit-active is high leaves the run bit at 1 and sets a sticky error output.
- R7: The receive and transmit enables are high exactly when the run bit is 1 and the block is not gated off by wait mode. The management enable does not depend on the run bit.
- R8: When power-down-in-wait is 1 and wait mode is high, all three enables are low. When power-down-in-wait is 0, wait mode has no effect.
- R9: Each time the receive enable falls, the abort and pause-clear outputs are high together for exactly one cycle, starting one cycle after the fall.
- R10: Software reset returns the control word, the write-once lock and the error flag to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous software reset of the control word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current control word |
| tx_active | input | 1 | Transmitter is sending a frame |
| mgmt_busy | input | 1 | MII management transfer in progress |
| wait_mode | input | 1 | Low-power wait mode |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| mgmt_en | output | 1 | MII management enable |
| rx_abort | output | 1 | One-cycle drop of the frame being received |
| pause_clr | output | 1 | One-cycle clear of the pause timeout |
| ext_phy_sel | output | 1 | Selects the external PHY |
| loopback_sel | output | 1 | Selects MAC loopback |
| err_blocked | output | 1 | Sticky flag: a disable was refused during transmit |

## Verification
The hard collisions are a write and a stop event that land on the same edge. One case is a write that clears the run bit while wait gating also drops the enables. The other is a refused disable (transmit active) that occurs while wait mode toggles, so the pulse must come from the wait path alone. A long random phase drives writes, transmit-active, busy, wait and software reset independently, so these coincidences occur many times. Each cycle is compared against a behavioural model that applies the write rules in order of precedence.

// File: rtl/emac_ctl_pkg.sv
package emac_ctl_pkg;

    localparam int unsigned CTL_W   = 8;
    localparam int unsigned B_RUN   = 7;
    localparam int unsigned B_WDIS  = 4;
    localparam int unsigned B_XPHY  = 3;
    localparam int unsigned B_LOOP  = 2;
    localparam int unsigned B_FDX   = 1;

    typedef struct packed {
        logic run;
        logic wdis;
        logic xphy;
        logic loop;
        logic fdx;
    } ctl_word_t;

    typedef enum logic [1:0] {
        EN_LOAD  = 2'd0,
        EN_HOLD0 = 2'd1,
        EN_HOLD1 = 2'd2
    } run_upd_t;

    function automatic logic [CTL_W-1:0] ctl_to_bus(input ctl_word_t c);
        logic [CTL_W-1:0] b;
        b         = '0;
        b[B_RUN]  = c.run;
        b[B_WDIS] = c.wdis;
        b[B_XPHY] = c.xphy;
        b[B_LOOP] = c.loop;
        b[B_FDX]  = c.fdx;
        return b;
    endfunction

endpackage

// File: rtl/emac_ctl_core.sv
module emac_ctl_core
    import emac_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             tx_active,
    input  logic             mgmt_busy,
    output ctl_word_t        ctl,
    output logic             err
);

    ctl_word_t ctl_q, ctl_d;
    logic      lock_q, lock_d;
    logic      err_q, err_d;
    logic      xphy_open;
    logic      mode_chg;
    run_upd_t  run_sel;

    always_comb begin
        xphy_open = !lock_q && !ctl_q.run && !mgmt_busy;
        ctl_d     = ctl_q;
        lock_d    = lock_q;
        err_d     = err_q;
        mode_chg  = 1'b0;
        run_sel   = EN_LOAD;
        if (wr_en) begin
            ctl_d.wdis = wr_data[B_WDIS];
            ctl_d.loop = wr_data[B_LOOP];
            ctl_d.fdx  = wr_data[B_FDX];
            if (xphy_open) begin
                ctl_d.xphy = wr_data[B_XPHY];
                lock_d     = 1'b1;
            end
            mode_chg = (ctl_d.xphy != ctl_q.xphy) || (ctl_d.loop != ctl_q.loop);
            if (wr_data[B_RUN] && !ctl_q.run && mode_chg)
                run_sel = EN_HOLD0;
            else if (!wr_data[B_RUN] && ctl_q.run && tx_active)
                run_sel = EN_HOLD1;
            else
                run_sel = EN_LOAD;
            case (run_sel)
                EN_HOLD0: ctl_d.run = 1'b0;
                EN_HOLD1: begin
                    ctl_d.run = 1'b1;
                    err_d     = 1'b1;
                end
                default:  ctl_d.run = wr_data[B_RUN];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            ctl_q  <= '0;
            lock_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            ctl_q  <= ctl_d;
            lock_q <= lock_d;
            err_q  <= err_d;
        end
    end

    assign ctl = ctl_q;
    assign err = err_q;

    assert_xphy_once_R3: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !sw_rst) |=> $stable(ctl_q.xphy));

    assert_xphy_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (ctl_q.run || mgmt_busy) && !sw_rst) |=> $stable(ctl_q.xphy));

    assert_mode_first_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ctl_q.run && wr_data[B_RUN] && !sw_rst &&
         (wr_data[B_LOOP] != ctl_q.loop)) |=> !ctl_q.run);

    assert_txact_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctl_q.run && !wr_data[B_RUN] && tx_active && !sw_rst)
        |=> (ctl_q.run && err_q));

    assert_swrst_clear_R10: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (ctl_q == '0 && !lock_q && !err_q));

endmodule

// File: rtl/emac_ctl_gate.sv
module emac_ctl_gate (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wdis,
    input  logic wait_mode,
    output logic rx_en,
    output logic tx_en,
    output logic mgmt_en,
    output logic stop_pulse
);

    logic sleep_off;
    logic live;
    logic live_q;
    logic pulse_q;

    always_comb begin
        sleep_off = wdis && wait_mode;
        live      = run && !sleep_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            live_q  <= live;
            pulse_q <= live_q && !live;
        end
    end

    assign rx_en      = live;
    assign tx_en      = live;
    assign mgmt_en    = !sleep_off;
    assign stop_pulse = pulse_q;

    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    assert_pulse_after_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_en) |=> stop_pulse);

    assert_mgmt_free_R7: assert property (@(posedge clk) disable iff (rst)
        rx_en |-> mgmt_en);

    assert_wait_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (wdis && wait_mode) |-> (!rx_en && !tx_en && !mgmt_en));

endmodule

// File: rtl/emac_ctl_reg.sv
module emac_ctl_reg
    import emac_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             tx_active,
    input  logic             mgmt_busy,
    input  logic             wait_mode,
    output logic             rx_en,
    output logic             tx_en,
    output logic             mgmt_en,
    output logic             rx_abort,
    output logic             pause_clr,
    output logic             ext_phy_sel,
    output logic             loopback_sel,
    output logic             err_blocked
);

    ctl_word_t ctl;
    logic      stop_pulse;

    emac_ctl_core u_core (
        .clk       (clk),
        .rst       (rst),
        .sw_rst    (sw_rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_active (tx_active),
        .mgmt_busy (mgmt_busy),
        .ctl       (ctl),
        .err       (err_blocked)
    );

    emac_ctl_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .run        (ctl.run),
        .wdis       (ctl.wdis),
        .wait_mode  (wait_mode),
        .rx_en      (rx_en),
        .tx_en      (tx_en),
        .mgmt_en    (mgmt_en),
        .stop_pulse (stop_pulse)
    );

    assign rd_data      = ctl_to_bus(ctl);
    assign rx_abort     = stop_pulse;
    assign pause_clr    = stop_pulse;
    assign ext_phy_sel  = ctl.xphy;
    assign loopback_sel = ctl.loop;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[6] == 1'b0 && rd_data[5] == 1'b0 && rd_data[0] == 1'b0));

endmodule

// File: tb/sim_emac_ctl_reg.sv
module sim_emac_ctl_reg;

    logic       clk = 1'b0;
    logic       rst, sw_rst, wr_en, tx_active, mgmt_busy, wait_mode;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       rx_en, tx_en, mgmt_en, rx_abort, pause_clr;
    logic       ext_phy_sel, loopback_sel, err_blocked;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    emac_ctl_reg u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tx_active(tx_active), .mgmt_busy(mgmt_busy),
        .wait_mode(wait_mode), .rx_en(rx_en), .tx_en(tx_en), .mgmt_en(mgmt_en),
        .rx_abort(rx_abort), .pause_clr(pause_clr), .ext_phy_sel(ext_phy_sel),
        .loopback_sel(loopback_sel), .err_blocked(err_blocked)
    );

    // behavioural reference state
    bit m_run, m_wdis, m_xphy, m_loop, m_fdx, m_lock, m_err, m_liveq, m_pulse;

    function automatic bit m_live();
        return m_run && !(m_wdis && wait_mode);
    endfunction

    function automatic logic [7:0] m_word();
        return {m_run, 2'b00, m_wdis, m_xphy, m_loop, m_fdx, 1'b0};
    endfunction

    always @(posedge clk) begin
        bit lv, nx, chg;
        lv = m_live();
        if (rst) begin
            {m_run, m_wdis, m_xphy, m_loop, m_fdx, m_lock, m_err, m_liveq, m_pulse} = '0;
        end else begin
            m_pulse = m_liveq && !lv;
            m_liveq = lv;
            if (sw_rst) begin
                {m_run, m_wdis, m_xphy, m_loop, m_fdx, m_lock, m_err} = '0;
            end else if (wr_en) begin
                nx = m_xphy;
                if (!m_lock && !m_run && !mgmt_busy) begin
                    nx = wr_data[3];
                    m_lock = 1;
                end
                chg = (nx != m_xphy) || (wr_data[2] != m_loop);
                if (wr_data[7] && !m_run && chg) m_run = 0;
                else if (!wr_data[7] && m_run && tx_active) begin
                    m_run = 1;
                    m_err = 1;
                end else m_run = wr_data[7];
                m_xphy = nx;
                m_wdis = wr_data[4];
                m_loop = wr_data[2];
                m_fdx  = wr_data[1];
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 word", rd_data, m_word());
            chk("R7 rx_en", {7'd0, rx_en}, {7'd0, m_live()});
            chk("R7 tx_en", {7'd0, tx_en}, {7'd0, m_live()});
            chk("R8 mgmt_en", {7'd0, mgmt_en}, {7'd0, !(m_wdis && wait_mode)});
            chk("R9 rx_abort", {7'd0, rx_abort}, {7'd0, m_pulse});
            chk("R9 pause_clr", {7'd0, pause_clr}, {7'd0, m_pulse});
            chk("R3 ext_phy_sel", {7'd0, ext_phy_sel}, {7'd0, m_xphy});
            chk("R5 loopback_sel", {7'd0, loopback_sel}, {7'd0, m_loop});
            chk("R6 err_blocked", {7'd0, err_blocked}, {7'd0, m_err});
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        step();
        wr_en = 0;
    endtask

    initial begin
        #1600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; sw_rst = 0; wr_en = 0; wr_data = 0;
        tx_active = 0; mgmt_busy = 0; wait_mode = 0;
        step(); step();
        rst = 0;
        step();
        // R2: reset state
        chk("R2 reset word", rd_data, 8'h00);
        chk("R2 mgmt_en", {7'd0, mgmt_en}, 8'h01);
        chk("R2 rx_en", {7'd0, rx_en}, 8'h00);
        // R4: busy write leaves xphy and lock untouched
        mgmt_busy = 1; wr(8'h08); mgmt_busy = 0;
        chk("R4 busy xphy", {7'd0, ext_phy_sel}, 8'h00);
        // R5: run with mode change -> run stays 0; R1 reserved bits ignored
        wr(8'hFF);
        chk("R5 run held", rd_data, 8'h1E);
        wr(8'h9E);
        chk("R7 running", {7'd0, rx_en}, 8'h01);
        // R3: locked, clearing xphy ignored
        wr(8'h96);
        chk("R3 locked", {7'd0, ext_phy_sel}, 8'h01);
        // R6: disable during transmit refused
        tx_active = 1; wr(8'h16); tx_active = 0;
        chk("R6 run kept", {7'd0, rd_data[7]}, 8'h01);
        chk("R6 err", {7'd0, err_blocked}, 8'h01);
        // R9: real disable, pulse one cycle later
        wr(8'h16);
        chk("R9 no pulse yet", {7'd0, rx_abort}, 8'h00);
        step();
        chk("R9 pulse", {7'd0, rx_abort}, 8'h01);
        step();
        chk("R9 pulse ends", {7'd0, rx_abort}, 8'h00);
        // R8: wait gating
        wr(8'h9E); wait_mode = 1; #1;
        chk("R8 gated", {5'd0, rx_en, tx_en, mgmt_en}, 8'h00);
        wr(8'h8E); #1;
        chk("R8 not gated", {5'd0, rx_en, tx_en, mgmt_en}, 8'h07);
        wait_mode = 0;
        // R10: software reset
        sw_rst = 1; step(); sw_rst = 0;
        chk("R10 word", rd_data, 8'h00);
        chk("R10 err", {7'd0, err_blocked}, 8'h00);
        wr(8'h08);
        chk("R10 lock cleared", {7'd0, ext_phy_sel}, 8'h01);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en     = ($urandom % 3) == 0;
            wr_data   = 8'($urandom);
            tx_active = ($urandom % 3) == 0;
            mgmt_busy = ($urandom % 4) == 0;
            wait_mode = ($urandom % 4) == 0;
            sw_rst    = ($urandom % 60) == 0;
            step();
        end
        wr_en = 0; sw_rst = 0;
        step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule